// File: doc/BRIEF.md
# SD Card SPI Byte Engine

This block is the bit-level worker under a larger SD card controller that talks to the card in SPI mode. The controller places a byte on the transmit input and pulses a start strobe. The engine then runs eight serial clock periods. During those periods it shifts the byte out toward the card and assembles the byte that the card shifts back. When the last bit is in, it raises a one-cycle completion pulse. Because all per-bit sequencing lives here, the controller's states deal only in whole bytes.

Chip select, the serial clock and the serial line toward the card all leave the block from dedicated flip-flops, so no decode glitch can reach the card. By default these flip-flops are clocked on the falling edge of the system clock, which keeps the added output delay to half a cycle. A parameter moves them to the rising edge instead. The card's serial output passes through a two-flop synchronizer before any shift register or state decision sees it. A chip-select request input lets the controller keep the card selected across a run of bytes.

Top module: `sdspi_byte_engine`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are cs_n=1, sck=0, card_din=1, busy=0, done=0 and rx_byte=0, until a start arrives.
- R2: The transmit byte goes out MSB first in SPI mode 0. The clock idles low, and card_din holds the bit for a period from the low half-period before each rising sck edge until that edge.
- R3: Each sck high phase and each low phase lasts exactly HALF_CLKS system clocks, and each byte produces exactly eight rising sck edges. The bit counter and the divider are both reloaded at every start.
- R4: rx_byte takes the synchronized card output sampled at the end of each sck high phase, MSB first. It changes only in the cycle in which done is high.
- R5: busy rises in the cycle after start is sampled and falls in the cycle in which done pulses. done is high for exactly one system clock per byte.
- R6: A start strobe seen while busy is high is ignored. The byte in flight and its timing are unchanged, and no extra done pulse follows.
- R7: cs_n is low while busy is high or while cs_req is high, and high otherwise. Holding cs_req keeps the card selected in the gap between bytes, and sck is never high while cs_n is high.
- R8: With OUT_NEGEDGE=1, cs_n, sck and card_din change only at falling edges of the system clock, never at rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe that begins a byte |
| tx_byte | input | DATA_W | Byte to send, taken when start is accepted |
| cs_req | input | 1 | Keeps chip select asserted between bytes |
| card_dout | input | 1 | Serial data from the card, asynchronous |
| cs_n | output | 1 | Registered active-low chip select |
| sck | output | 1 | Registered serial clock |
| card_din | output | 1 | Registered serial data toward the card |
| rx_byte | output | DATA_W | Last byte received from the card |
| done | output | 1 | One-cycle pulse when a byte completes |
| busy | output | 1 | High while a byte is in flight |

## Verification
The bench uses DATA_W=8, HALF_CLKS=3 and OUT_NEGEDGE=1. With three clocks per half-period, the card model's change after each falling sck edge reaches the capture point through the two synchronizer stages, so real round-trip data can be checked. The falling-edge launch can also be told apart from the rising edge by sampling the pins right after each rising edge. Byte patterns with all ones, all zeros and single bits at the ends exercise the MSB-first order in both directions. A start pulse during a byte and a run of bytes with chip select held bring the ignore rule and the hold rule within reach.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

endpackage

// File: rtl/sdspi_sync.sv
module sdspi_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sdspi_halfdiv.sv
module sdspi_halfdiv #(
    parameter int HALF_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CLKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run)      cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: the half-period count never leaves its range
    a_r3_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R3: a fresh run starts from a cleared count
    a_r3_div_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/sdspi_pinreg.sv
module sdspi_pinreg #(
    parameter int   W       = 3,
    parameter bit   NEGEDGE = 1'b1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_d,
    output logic [W-1:0] pin_q
);
    generate
        if (NEGEDGE) begin : g_fall
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) pin_q <= RST_VAL;
                else        pin_q <= pin_d;
            end
        end else begin : g_rise
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pin_q <= RST_VAL;
                else        pin_q <= pin_d;
            end
        end
    endgenerate
endmodule

// File: rtl/sdspi_byte_engine.sv
module sdspi_byte_engine
    import sdspi_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int HALF_CLKS   = 4,
    parameter bit OUT_NEGEDGE = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              cs_req,
    input  logic              card_dout,
    output logic              cs_n,
    output logic              sck,
    output logic              card_din,
    output logic [DATA_W-1:0] rx_byte,
    output logic              done,
    output logic              busy
);
    localparam int BC_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [BC_W-1:0] BC_TOP = BC_W'(DATA_W - 1);

    typedef struct packed {
        phase_e            phase;
        logic [BC_W-1:0]   bit_cnt;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_sh;
        logic [DATA_W-1:0] rx;
        logic              done;
    } eng_s;

    eng_s eng_q, eng_d;
    logic din_s;
    logic tick;
    logic run;
    logic [2:0] pins_d;
    logic [2:0] pins_q;
    logic [DATA_W-1:0] rx_next;

    sdspi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (card_dout),
        .dout (din_s)
    );

    assign run = (eng_q.phase != PH_IDLE);

    sdspi_halfdiv #(.HALF_CLKS(HALF_CLKS)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    generate
        if (DATA_W > 1) begin : g_rxw
            assign rx_next = {eng_q.rx_sh[DATA_W-2:0], din_s};
        end else begin : g_rx1
            assign rx_next = din_s;
        end
    endgenerate

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        unique case (eng_q.phase)
            PH_IDLE: begin
                if (start) begin
                    eng_d.phase   = PH_LOW;
                    eng_d.bit_cnt = BC_TOP;
                    eng_d.tx_sh   = tx_byte;
                end
            end
            PH_LOW: begin
                if (tick) eng_d.phase = PH_HIGH;
            end
            PH_HIGH: begin
                if (tick) begin
                    eng_d.rx_sh = rx_next;
                    eng_d.tx_sh = eng_q.tx_sh << 1;
                    if (eng_q.bit_cnt == '0) begin
                        eng_d.phase = PH_IDLE;
                        eng_d.rx    = rx_next;
                        eng_d.done  = 1'b1;
                    end else begin
                        eng_d.phase   = PH_LOW;
                        eng_d.bit_cnt = eng_q.bit_cnt - 1'b1;
                    end
                end
            end
            default: eng_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q.phase   <= PH_IDLE;
            eng_q.bit_cnt <= '0;
            eng_q.tx_sh   <= '0;
            eng_q.rx_sh   <= '0;
            eng_q.rx      <= '0;
            eng_q.done    <= 1'b0;
        end else begin
            eng_q <= eng_d;
        end
    end

    // pin order: {cs_n, sck, card_din}
    always_comb begin
        pins_d[2] = ~(run | cs_req);
        pins_d[1] = (eng_q.phase == PH_HIGH);
        pins_d[0] = run ? eng_q.tx_sh[DATA_W-1] : 1'b1;
    end

    sdspi_pinreg #(.W(3), .NEGEDGE(OUT_NEGEDGE), .RST_VAL(3'b101)) u_pins (
        .clk  (clk),
        .rst_n(rst_n),
        .pin_d(pins_d),
        .pin_q(pins_q)
    );

    assign cs_n     = pins_q[2];
    assign sck      = pins_q[1];
    assign card_din = pins_q[0];
    assign rx_byte  = eng_q.rx;
    assign done     = eng_q.done;
    assign busy     = run;

    // R5: completion pulse is one cycle wide
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: busy only ends together with done
    a_r5_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R4: received byte changes only with done
    a_r4_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> done);

    // R6: start during a byte does not reload the bit counter
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && eng_q.bit_cnt != BC_TOP) |=> eng_q.bit_cnt != BC_TOP);

    // R7: clock never pulses with the card deselected
    a_r7_sck_selected: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);
endmodule

// File: tb/sdspi_byte_engine_tb.sv
module sdspi_byte_engine_tb;
    localparam int HALF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic cs_req = 1'b0;
    logic card_dout;
    logic cs_n, sck, card_din, done, busy;
    logic [7:0] rx_byte;

    always #4 clk = ~clk;

    sdspi_byte_engine #(.DATA_W(8), .HALF_CLKS(HALF), .OUT_NEGEDGE(1'b1), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(tx_byte), .cs_req(cs_req),
        .card_dout(card_dout), .cs_n(cs_n), .sck(sck), .card_din(card_din),
        .rx_byte(rx_byte), .done(done), .busy(busy)
    );

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] q_rx[$];
    logic [7:0] q_tx[$];

    logic [7:0] card_sh = 8'hFF;
    logic [7:0] card_in = 8'h00;
    int card_n = 0;
    int hi_cnt = 0;
    int hi_bad = 0;
    int edge_bad = 0;
    logic done_prev = 1'b0;

    assign card_dout = card_sh[7];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // card model: sample on rising sck, shift on falling sck
    always @(posedge sck) begin
        if (rst_n) chk("R7 cs_n low at sck rise", {31'd0, cs_n}, 32'd0);
        card_in = {card_in[6:0], card_din};
        card_n++;
    end
    always @(negedge sck) card_sh = {card_sh[6:0], 1'b1};

    // R3: high phase width
    always @(posedge clk) begin
        if (sck) hi_cnt++;
        else if (hi_cnt != 0) begin
            if (hi_cnt != HALF) hi_bad++;
            hi_cnt = 0;
        end
    end

    // R8: pins must not move at rising edges
    always @(posedge clk) begin
        logic [2:0] pre;
        pre = {cs_n, sck, card_din};
        #1;
        if ({cs_n, sck, card_din} !== pre) edge_bad++;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && done_prev) chk("R5 done one cycle", {31'd0, done}, 32'd0);
        if (rst_n && done) begin
            chk("R5 busy low with done", {31'd0, busy}, 32'd0);
            chk("R3 eight sck rises", card_n, 8);
            if (q_rx.size() == 0) begin
                chk("R6 unexpected done", 32'd1, 32'd0);
            end else begin
                chk("R4 rx_byte", {24'd0, rx_byte}, {24'd0, q_rx.pop_front()});
                chk("R2 card saw tx", {24'd0, card_in}, {24'd0, q_tx.pop_front()});
            end
        end
        done_prev = done;
    end

    task automatic xfer(input logic [7:0] tx, input logic [7:0] cd, input bit poke);
        #1;
        card_sh = cd;
        card_n = 0;
        q_tx.push_back(tx);
        q_rx.push_back(cd);
        @(negedge clk);
        start = 1'b1;
        tx_byte = tx;
        @(negedge clk);
        start = 1'b0;
        tx_byte = ~tx;
        chk("R5 busy after start", {31'd0, busy}, 32'd1);
        if (poke) begin
            repeat (10) @(negedge clk);
            tx_byte = 8'h11;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 cs_n in reset", {31'd0, cs_n}, 32'd1);
        chk("R1 outputs in reset", {24'd0, rx_byte}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle pins", {29'd0, cs_n, sck, card_din}, 32'b101);
        chk("R1 idle flags", {30'd0, busy, done}, 32'd0);

        xfer(8'hA5, 8'h3C, 1'b0);
        xfer(8'hFF, 8'h00, 1'b0);
        xfer(8'h00, 8'hFF, 1'b0);
        xfer(8'h81, 8'h7E, 1'b0);
        repeat (3) @(negedge clk);
        chk("R7 deselected when idle", {31'd0, cs_n}, 32'd1);

        cs_req = 1'b1;
        xfer(8'h12, 8'h34, 1'b0);
        repeat (3) @(negedge clk);
        chk("R7 held between bytes", {31'd0, cs_n}, 32'd0);
        xfer(8'hC3, 8'h5A, 1'b0);
        cs_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 released", {31'd0, cs_n}, 32'd1);

        xfer(8'h6B, 8'h96, 1'b1);
        repeat (40) @(negedge clk);
        chk("R6 no second byte", {31'd0, busy}, 32'd0);
        chk("R6 scoreboard empty", q_rx.size(), 0);
        chk("R6 rx kept", {24'd0, rx_byte}, 32'h96);

        chk("R3 high width", hi_bad, 0);
        chk("R8 no change at rising edge", edge_bad, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule